// File: doc/BRIEF.md
# Four-Channel DMA Request Priority Arbiter

This block decides which of four DMA channels gets the bus when several of them request at once. Each channel supplies a request line and a 3-bit bandwidth-control setting. The default ranking is by index, with channel 0 first and channel 3 last. A channel whose setting is all zeros can move up one place. It then outranks the channel directly below it in index, but only when that neighbour's own setting is not zero. It never outranks any channel further away.

The decision is registered. While a channel holds the grant, the grant stays fixed no matter what the requests or settings do. A new decision is taken on the clock edge where the owner asserts a release, or on any edge while nothing is granted. If no channel is requesting at that edge, the grant goes to zero and the valid flag drops.

Top module: `dma_prio_arb`

## Requirements
- R1: While reset is asserted, and right after it is released, the grant is 0000 and the valid flag is low.
- R2: When every channel's setting is nonzero, the lowest-indexed requesting channel wins. Equal nonzero settings do not change this.
- R3: A channel i ≥ 1 whose setting is 000 beats channel i−1 when the setting of channel i−1 is nonzero. Two such swaps on disjoint pairs can hold at once. For example, with channels 1 and 3 at zero and channels 0 and 2 nonzero, the order is 1, 0, 3, 2.
- R4: A channel whose setting is 000 gains nothing when channel i−1 also has 000. With channels 0 and 1 both at zero, channel 0 still wins. With channels 2 and 3 at zero and channel 1 nonzero, channel 2 beats channel 1 and channel 3 stays behind channel 2.
- R5: A zero setting never lets a channel beat any channel other than its immediate predecessor. For example, channel 3 at zero still loses to channel 1.
- R6: A zero setting on channel 0 has no effect on the order.
- R7: The grant has at most one bit set, and the valid flag is high exactly when a bit is set. Bit i of the grant means channel i.
- R8: While the valid flag is high and release is low, the grant does not change on the next edge.
- R9: On an edge where the valid flag is low or release is high, and no request is active, the grant becomes 0000 and the valid flag goes low.
- R10: On an edge where a decision is taken and some request is active, the new grant is the top-ranked requesting channel under R2 to R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Per-channel request, bit i for channel i |
| bw_cfg_i | input | 12 | Bandwidth settings; bits [3i+2:3i] belong to channel i |
| release_i | input | 1 | The current owner gives up the grant; a new decision is taken on this edge |
| grant_o | output | 4 | One-hot grant, bit i for channel i |
| grant_vld_o | output | 1 | High while a channel holds the grant |

## Verification
The hardest situations to reach are the ones where several zero settings interact in a single decision: two disjoint swaps at once, a chain of adjacent zeros in which only the first zero counts, and requests placed on both channels of each affected pair. Directed decisions set up each of these arrangements by hand. A long random phase then draws every setting as zero half of the time and pulses release at random, so the hold path and the decision path are both hit under changing requests. A behavioural model builds the ranking as an explicit ordered list and tracks the held grant, and its result is compared with the outputs on every cycle.

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH  = 4,
  parameter int BW_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      req_i,
  input  logic [NCH*BW_W-1:0] bw_cfg_i,
  input  logic                release_i,
  output logic [NCH-1:0]      grant_o,
  output logic                grant_vld_o
);

  localparam int CFG_W = NCH * BW_W;

  logic [NCH-1:0] bw_zero;
  logic [NCH-1:0] swap_up;
  logic [NCH-1:0] win;
  logic [NCH-1:0] grant_q;
  logic [NCH-1:0] beaten_by [NCH];
  logic [CFG_W-1:0] cfg;

  assign cfg = bw_cfg_i;

  genvar g;
  for (g = 0; g < NCH; g++) begin : g_zero
    assign bw_zero[g] = (cfg[g*BW_W +: BW_W] == '0);
  end

  assign swap_up[0] = 1'b0;
  for (g = 1; g < NCH; g++) begin : g_swap
    assign swap_up[g] = bw_zero[g] & ~bw_zero[g-1];
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      beaten_by[i] = '0;
      for (int j = 0; j < NCH; j++) begin
        if (j < i && !(j == i - 1 && swap_up[i]))
          beaten_by[i][j] = 1'b1;
        else if (j == i + 1 && swap_up[j])
          beaten_by[i][j] = 1'b1;
      end
    end
  end

  for (g = 0; g < NCH; g++) begin : g_win
    assign win[g] = req_i[g] & ~|(req_i & beaten_by[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      grant_q <= '0;
    else if (!grant_vld_o || release_i)
      grant_q <= win;
  end

  assign grant_o     = grant_q;
  assign grant_vld_o = |grant_q;

endmodule

module dma_prio_arb_chk #(
  parameter int NCH  = 4,
  parameter int BW_W = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NCH-1:0]      req_i,
  input logic [NCH*BW_W-1:0] bw_cfg_i,
  input logic                release_i,
  input logic [NCH-1:0]      grant_o,
  input logic                grant_vld_o
);

  logic           decide;
  logic           all_nz;
  logic [NCH-1:0] lowest;

  assign decide = !grant_vld_o || release_i;
  assign lowest = req_i & (~req_i + 1'b1);

  always_comb begin
    all_nz = 1'b1;
    for (int i = 0; i < NCH; i++)
      if (bw_cfg_i[i*BW_W +: BW_W] == '0) all_nz = 1'b0;
  end

  always @(posedge clk)
    if (!rst_n) AST_RST_IDLE: assert (grant_o == '0 && !grant_vld_o); // R1

  AST_FIXED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    decide && all_nz |=> grant_o == $past(lowest)); // R2

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && (grant_vld_o == ($countones(grant_o) == 1))); // R7

  AST_HOLD_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld_o && !release_i |=> $stable(grant_o)); // R8

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    decide && req_i == '0 |=> !grant_vld_o); // R9

  AST_GRANT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    decide && req_i != '0 |=> grant_vld_o && ((grant_o & $past(req_i)) != '0)); // R10

endmodule

bind dma_prio_arb dma_prio_arb_chk #(.NCH(NCH), .BW_W(BW_W)) u_chk (.*);

// File: tb/dma_prio_arb_tb.sv
`timescale 1ns/1ps
module dma_prio_arb_tb_top;
  localparam int NCH = 4;
  localparam int BW_W = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req = '0;
  logic [11:0] bw = 12'h249;
  logic        rel = 1'b0;
  logic [3:0]  grant;
  logic        vld;
  logic [3:0]  m_grant;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;
  string       tag = "R1";

  always #2.5 clk = ~clk;

  dma_prio_arb #(.NCH(NCH), .BW_W(BW_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .bw_cfg_i(bw),
    .release_i(rel), .grant_o(grant), .grant_vld_o(vld)
  );

  function automatic logic [3:0] pick(input logic [3:0] r, input logic [11:0] c);
    int ord [4];
    int t;
    for (int i = 0; i < 4; i++) ord[i] = i;
    for (int i = 1; i < 4; i++)
      if (c[i*3 +: 3] == 3'd0 && c[(i-1)*3 +: 3] != 3'd0) begin
        t = ord[i-1]; ord[i-1] = ord[i]; ord[i] = t;
      end
    for (int k = 0; k < 4; k++)
      if (r[ord[k]]) return 4'b0001 << ord[k];
    return 4'b0000;
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) m_grant <= '0;
    else if (m_grant == '0 || rel) m_grant <= pick(req, bw);

  task automatic check(input string r, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: vld,grant=%b expected %b at %0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk)
    if (rst_n && !done) check({tag, " model"}, {vld, grant}, {m_grant != 4'd0, m_grant});

  task automatic decide(input string r, input logic [3:0] rq, input logic [11:0] c,
                        input logic [3:0] exp);
    @(negedge clk);
    tag = r; req = rq; bw = c; rel = 1'b1;
    @(negedge clk);
    rel = 1'b0;
    check(r, {vld, grant}, {exp != 4'd0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {vld, grant}, 5'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {vld, grant}, 5'b0);

    decide("R2", 4'b1111, 12'h249, 4'b0001);
    decide("R2", 4'b1100, 12'hFFF, 4'b0100);
    decide("R3", 4'b0011, 12'h241, 4'b0010);
    decide("R3", 4'b1100, 12'h049, 4'b1000);
    decide("R3", 4'b1111, 12'h041, 4'b0010);
    decide("R3", 4'b1101, 12'h041, 4'b0001);
    decide("R4", 4'b0011, 12'h240, 4'b0001);
    decide("R4", 4'b1110, 12'h009, 4'b0100);
    decide("R4", 4'b1010, 12'h009, 4'b0010);
    decide("R5", 4'b1010, 12'h049, 4'b0010);
    decide("R6", 4'b0011, 12'h248, 4'b0001);

    decide("R8", 4'b0100, 12'h249, 4'b0100);
    req = 4'b0001; bw = 12'h000;
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      check("R8", {vld, grant}, 5'b10100);
    end
    decide("R9", 4'b0000, 12'h249, 4'b0000);
    @(negedge clk);
    check("R9", {vld, grant}, 5'b0);

    tag = "R10";
    for (int n = 0; n < 500; n++) begin
      @(negedge clk);
      req = 4'($urandom);
      for (int i = 0; i < 4; i++)
        bw[i*3 +: 3] = ($urandom_range(0, 1) == 0) ? 3'd0 : 3'($urandom_range(1, 7));
      rel = ($urandom_range(0, 3) == 0);
    end
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule